// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This block turns a comparator flag, which reports that the supply rail is below its trip level, into a clean system reset line. The flag is brought into the clock domain through a synchroniser chain. It must then stay high for a minimum number of consecutive clock samples before it counts as a real undervoltage event, so brief negative dips are filtered out. A qualified event drives the reset line active after a short fixed latency. When the supply recovers, the reset is held for a long, parameterised timeout. A fresh qualified event during that timeout starts the timeout over from its full length.

An asynchronous power-on initialisation input forces reset active at once. Reset stays active after that input is released until a complete timeout has run with the supply good. The active level of the reset line is chosen by a parameter. The glitch window, the assertion latency and the timeout are all given in clock cycles, so a system clock of known frequency maps them onto real time.

Top module: `supply_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_out` is at its active level. After `por_n` rises with `uv_flag` low, `rst_out` stays active and returns inactive on the (SYNC_STAGES+ASSERT_DELAY+HOLD_CYCLES+2)th rising clock edge after the release.
- R2: With ACTIVE_HIGH=1 the active level of `rst_out` is 1, and with ACTIVE_HIGH=0 it is 0. Otherwise the two variants behave identically.
- R3: A high pulse on `uv_flag` that lasts fewer than GLITCH_CYCLES consecutive clock samples never drives an inactive `rst_out` active.
- R4: When `uv_flag` is sampled high on GLITCH_CYCLES consecutive edges, `rst_out` becomes active on the (SYNC_STAGES+GLITCH_CYCLES+ASSERT_DELAY)th edge after the first of those samples.
- R5: `rst_out` stays active for as long as `uv_flag` keeps being sampled high after qualifying.
- R6: After the last high sample of a qualified event, `rst_out` returns inactive on the (SYNC_STAGES+ASSERT_DELAY+HOLD_CYCLES+2)th edge, provided no other event qualifies in the meantime.
- R7: A new qualified event during the hold timeout reloads the timeout, so the release is measured from the last high sample of the newest event.
- R8: A sub-threshold pulse (shorter than GLITCH_CYCLES samples) during the hold timeout neither shortens nor extends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| uv_flag | input | 1 | Asynchronous comparator flag, high when the supply is below its trip level |
| rst_out | output | 1 | System reset line, active level set by ACTIVE_HIGH |

## Verification
A corrupted qualification counter shows up at the ports as a wrong assertion latency, or as a sub-threshold pulse that asserts reset. Both appear within GLITCH_CYCLES plus a few edges of the stimulus. A wrong hold counter or reload path moves the release edge. The shift appears one timeout after the last qualified sample, so the bench compares every cycle against a model of the reset window and keeps the timeout short. A lost power-on value shows up in the first cycles after `por_n` is released.

// File: rtl/supv_pkg.sv
package supv_pkg;

   // Number of bits needed to hold the value max_val.
   function automatic int cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("supv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // At power-on the supply is assumed to be below threshold.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/supv_dip_filter.sv
module supv_dip_filter
   import supv_pkg::*;
#(
   parameter int GLITCH_CYCLES = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic uv_s,
   output logic dip_q
);
   localparam int W = cnt_bits(GLITCH_CYCLES);
   localparam logic [W-1:0] FULL = W'(GLITCH_CYCLES);

   logic [W-1:0] run_len;

   // Count consecutive low-supply samples, saturating at the window length.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)            run_len <= FULL;
      else if (!uv_s)        run_len <= '0;
      else if (run_len != FULL) run_len <= run_len + 1'b1;
   end

   assign dip_q = (run_len == FULL);

   // R3
   qual_needs_low_supply_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(dip_q) |-> $past(uv_s));

   // R5
   dip_persists_chk: assert property (@(posedge clk) disable iff (!por_n)
      (dip_q && uv_s) |=> dip_q);
endmodule

// File: rtl/supv_delay.sv
module supv_delay #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   output logic dout
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else begin : g_pipe
         logic [DEPTH-1:0] pipe;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) pipe <= '1;
            else if (DEPTH == 1) pipe <= din;
            else pipe <= {pipe[DEPTH-2:0], din};
         end
         assign dout = pipe[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/supv_hold.sv
module supv_hold
   import supv_pkg::*;
#(
   parameter int HOLD_CYCLES = 40
) (
   input  logic clk,
   input  logic por_n,
   input  logic dip_d,
   output logic active
);
   localparam int W = cnt_bits(HOLD_CYCLES);
   localparam logic [W-1:0] FULL = W'(HOLD_CYCLES);

   logic [W-1:0] remain;
   logic         act_q;

   // Reload on every qualified sample, count down once the supply is good.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              remain <= FULL;
      else if (dip_d)          remain <= FULL;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) act_q <= 1'b1;
      else        act_q <= dip_d || (remain != '0);
   end

   assign active = act_q;

   // R6
   hold_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
      remain <= FULL);

   // R4
   assert_follows_dip_chk: assert property (@(posedge clk) disable iff (!por_n)
      dip_d |=> active);

   // R7
   reload_full_chk: assert property (@(posedge clk) disable iff (!por_n)
      dip_d |=> (remain == FULL));

   // R6
   release_when_expired_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(active) |-> (!$past(dip_d) && ($past(remain) == '0)));
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
   parameter int SYNC_STAGES   = 2,
   parameter int GLITCH_CYCLES = 200,
   parameter int ASSERT_DELAY  = 16,
   parameter int HOLD_CYCLES   = 12_000_000,
   parameter bit ACTIVE_HIGH   = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic uv_flag,
   output logic rst_out
);
   localparam logic ACT_LVL = ACTIVE_HIGH;

   generate
      if (GLITCH_CYCLES < 1) begin : g_bad_glitch
         $error("supply_reset_gen: GLITCH_CYCLES must be at least 1");
      end
      if (ASSERT_DELAY < 0 || ASSERT_DELAY > 64) begin : g_bad_delay
         $error("supply_reset_gen: ASSERT_DELAY must lie in 0..64");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("supply_reset_gen: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic uv_s;
   logic dip_q;
   logic dip_d;
   logic active;

   supv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .d_async(uv_flag), .q_sync(uv_s));

   supv_dip_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filt (
      .clk(clk), .por_n(por_n), .uv_s(uv_s), .dip_q(dip_q));

   supv_delay #(.DEPTH(ASSERT_DELAY)) u_dly (
      .clk(clk), .por_n(por_n), .din(dip_q), .dout(dip_d));

   supv_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .por_n(por_n), .dip_d(dip_d), .active(active));

   generate
      if (ACTIVE_HIGH) begin : g_pos
         assign rst_out = active;
      end else begin : g_neg
         assign rst_out = ~active;
      end
   endgenerate

   // R1
   por_forces_reset_chk: assert property (@(posedge clk)
      !por_n |-> (rst_out == ACT_LVL));
endmodule

// File: tb/tb_supply_reset_gen.sv
module tb_supply_reset_gen;
   localparam int SYNC = 2;
   localparam int G    = 4;
   localparam int D    = 3;
   localparam int H    = 40;
   localparam int LAT_LO = SYNC + D + 1;
   localparam int LAT_HI = SYNC + D + H + 1;
   localparam int HIST = 8192;

   logic clk = 1'b0;
   logic por_n;
   logic uv_flag;
   logic rst_lo;
   logic rst_hi;

   int checks = 0;
   int bad = 0;
   int ncyc = 0;
   int runlen = G;
   bit qhist [HIST];
   string phase = "R1";

   always #10 clk = ~clk;

   supply_reset_gen #(.SYNC_STAGES(SYNC), .GLITCH_CYCLES(G), .ASSERT_DELAY(D),
      .HOLD_CYCLES(H), .ACTIVE_HIGH(1'b0)) dut (
      .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .rst_out(rst_lo));

   supply_reset_gen #(.SYNC_STAGES(SYNC), .GLITCH_CYCLES(G), .ASSERT_DELAY(D),
      .HOLD_CYCLES(H), .ACTIVE_HIGH(1'b1)) dut_hi (
      .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .rst_out(rst_hi));

   // Reset is active after edge n when any qualified sample lies in the window.
   function automatic bit expect_active(input int n);
      for (int i = n - LAT_HI; i <= n - LAT_LO; i++) begin
         if (i < 0) return 1'b1;
         if (qhist[i]) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp_v);
      checks++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s cycle=%0d actual=%b expected=%b", req, ncyc, act, exp_v);
      end
   endtask

   task automatic check_both(input bit e);
      chk(phase, rst_lo, ~e);
      chk("R2", rst_hi, e);
   endtask

   task automatic step(input bit v);
      uv_flag = v;
      @(posedge clk);
      if (v) runlen = (runlen < G) ? runlen + 1 : G;
      else   runlen = 0;
      if (ncyc < HIST) qhist[ncyc] = v && (runlen >= G);
      @(negedge clk);
      check_both(expect_active(ncyc));
      ncyc++;
   endtask

   task automatic burst(input bit v, input int len);
      for (int k = 0; k < len; k++) step(v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      por_n = 1'b1;
      uv_flag = 1'b0;
      #3 por_n = 1'b0;
      // R1: reset active during power-on initialisation
      repeat (4) begin
         @(negedge clk);
         chk("R1", rst_lo, 1'b0);
         chk("R1", rst_hi, 1'b1);
      end
      por_n = 1'b1;
      phase = "R1";
      burst(1'b0, 60);

      // R3: sub-threshold pulses from an idle, released state
      phase = "R3";
      for (int len = 1; len < G; len++) begin
         burst(1'b1, len);
         burst(1'b0, 12);
      end

      // R4 / R5 / R6: one long qualified dip, then recovery
      phase = "R4";
      burst(1'b1, G);
      phase = "R5";
      burst(1'b1, 12);
      phase = "R6";
      burst(1'b0, H + 20);

      // R7: second qualified dip inside the hold restarts it
      phase = "R7";
      burst(1'b1, G);
      burst(1'b0, 20);
      burst(1'b1, G);
      burst(1'b0, H + 20);

      // R8: a short pulse inside the hold has no effect on the release
      phase = "R8";
      burst(1'b1, G);
      burst(1'b0, 15);
      burst(1'b1, G - 1);
      burst(1'b0, H + 20);

      // Exact-threshold corner: G samples qualify, G-1 does not (R4, R3)
      phase = "R4";
      burst(1'b1, G);
      burst(1'b0, H + 10);
      phase = "R3";
      burst(1'b1, G - 1);
      burst(1'b0, 10);

      // Random pulses and gaps around the glitch window and the timeout
      phase = "R6";
      while (ncyc < 4000) begin
         burst(1'b1, 1 + $urandom_range(0, 2 * G));
         burst(1'b0, 1 + $urandom_range(0, H + 10));
      end

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule